// File: doc/BRIEF.md
# Branch Target Buffer with Allocate-on-Taken

This block remembers recently taken branches and predicts, for a fetch address, whether the branch there will be taken and where it goes. It holds a small direct-mapped table. Each slot carries a valid flag, an address tag, a stored target and a two-bit confidence counter. The counter has four named states: `CNT_NT_STRONG` (0), `CNT_NT_WEAK` (1), `CNT_T_WEAK` (2) and `CNT_T_STRONG` (3). The two upper states predict taken.

The lookup side is purely combinational on the current table contents. The update side takes a resolved branch address, its real outcome and its target, and writes on the next clock edge. A branch with no slot is predicted not taken. A slot is created only when a branch first resolves taken, and it starts in `CNT_T_STRONG`. A fresh branch therefore goes straight from "absent" to state 3 and never passes through states 1 and 2.

The counter transitions on a hit are as follows. `INC` moves 0→1→2→3 on a taken outcome and saturates at 3. `DEC` moves 3→2→1→0 on a not-taken outcome and saturates at 0. `ALLOC` moves an absent branch to 3 on a taken outcome. An absent branch that resolves not taken makes no transition.

Top module: `branch_target_buffer`

## Requirements
- R1: After reset every slot is invalid, so every lookup reports a miss.
- R2: A lookup that misses reports hit=0, taken=0 and target=0.
- R3: An update that misses and resolves not taken changes no slot, and that address still misses afterwards.
- R4: An update that misses and resolves taken fills the slot with valid=1, the tag, the target and state 3 (`CNT_T_STRONG`), so the next lookup hits and predicts taken with that target.
- R5: An update that hits with a taken outcome raises the state by one, saturating at 3, and replaces the stored target with the new one.
- R6: An update that hits with a not-taken outcome lowers the state by one, saturating at 0, and keeps the stored target.
- R7: A lookup that hits predicts taken exactly when the state is 2 or 3. From state 0, two taken outcomes are needed before the prediction becomes taken. From state 3, two not-taken outcomes are needed before it becomes not taken.
- R8: An allocation to a slot that holds a different valid tag replaces that slot, and the old address then misses.
- R9: When a lookup and an update fall on the same slot in the same cycle, the lookup returns the contents as they were before the update.
- R10: The slot index is address bits [IDX_W-1:0] and the tag is the remaining upper bits. With the defaults, the index is bits [3:0] and the tag is bits [15:4].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | ADDR_W | Fetch address to look up |
| lk_hit | output | 1 | Lookup found a matching valid slot |
| lk_taken | output | 1 | Predicted taken |
| lk_target | output | ADDR_W | Predicted target (0 on miss) |
| up_valid | input | 1 | Resolved-branch update present |
| up_pc | input | ADDR_W | Resolved branch address |
| up_taken | input | 1 | Actual outcome |
| up_target | input | ADDR_W | Actual target |

## Verification
The hardest case to reach is a same-cycle lookup and update on one slot where the update changes the prediction. For example, a not-taken update can drop a slot from state 2 to state 1, or an allocation can evict another tag. To observe either, the lookup must return the old value, and this needs a prepared slot history. The directed part of the bench builds that history on one index: it allocates, walks the counter down to 0 and back up to 3, and overlaps lookups with updates along the way. A random phase then draws addresses from a small pool of tags that share indices, so conflicts, saturation and same-slot overlaps recur often.

// File: rtl/btb_pkg.sv
package btb_pkg;

    typedef enum logic [1:0] {
        CNT_NT_STRONG = 2'd0,
        CNT_NT_WEAK   = 2'd1,
        CNT_T_WEAK    = 2'd2,
        CNT_T_STRONG  = 2'd3
    } ctr_state_t;

    function automatic logic ctr_predicts_taken(ctr_state_t s);
        logic p;
        unique case (s)
            CNT_NT_STRONG: p = 1'b0;
            CNT_NT_WEAK:   p = 1'b0;
            CNT_T_WEAK:    p = 1'b1;
            CNT_T_STRONG:  p = 1'b1;
            default:       p = 1'b0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/btb_sat_counter.sv
module btb_sat_counter
    import btb_pkg::*;
(
    input  ctr_state_t cur,
    input  logic       alloc,
    input  logic       taken,
    output ctr_state_t nxt
);

    always_comb begin
        if (alloc) begin
            nxt = CNT_T_STRONG;
        end else begin
            unique case (cur)
                CNT_NT_STRONG: nxt = taken ? CNT_NT_WEAK  : CNT_NT_STRONG;
                CNT_NT_WEAK:   nxt = taken ? CNT_T_WEAK   : CNT_NT_STRONG;
                CNT_T_WEAK:    nxt = taken ? CNT_T_STRONG : CNT_NT_WEAK;
                CNT_T_STRONG:  nxt = taken ? CNT_T_STRONG : CNT_T_WEAK;
                default:       nxt = CNT_NT_STRONG;
            endcase
        end
    end

endmodule

// File: rtl/btb_storage.sv
module btb_storage
    import btb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 4,
    localparam int ENTRIES = 1 << IDX_W,
    localparam int TAG_W   = ADDR_W - IDX_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [TAG_W-1:0]            wr_tag,
    input  logic [ADDR_W-1:0]           wr_tgt,
    input  ctr_state_t                  wr_st,
    input  logic [IDX_W-1:0]            a_idx,
    output logic                        a_vld,
    output logic [TAG_W-1:0]            a_tag,
    output logic [ADDR_W-1:0]           a_tgt,
    output ctr_state_t                  a_st,
    input  logic [IDX_W-1:0]            b_idx,
    output logic                        b_vld,
    output logic [TAG_W-1:0]            b_tag,
    output logic [ADDR_W-1:0]           b_tgt,
    output ctr_state_t                  b_st,
    output logic [ENTRIES-1:0]          vld_all,
    output logic [ENTRIES-1:0][1:0]     st_all
);

    logic [TAG_W-1:0]  tag_q [ENTRIES];
    logic [ADDR_W-1:0] tgt_q [ENTRIES];
    ctr_state_t        st_q  [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_all[g] <= 1'b0;
                tag_q[g]   <= '0;
                tgt_q[g]   <= '0;
                st_q[g]    <= CNT_NT_STRONG;
            end else if (we && wr_idx == IDX_W'(g)) begin
                vld_all[g] <= 1'b1;
                tag_q[g]   <= wr_tag;
                tgt_q[g]   <= wr_tgt;
                st_q[g]    <= wr_st;
            end
        end
        assign st_all[g] = st_q[g];
    end

    always_comb begin
        a_vld = vld_all[a_idx];
        a_tag = tag_q[a_idx];
        a_tgt = tgt_q[a_idx];
        a_st  = st_q[a_idx];
        b_vld = vld_all[b_idx];
        b_tag = tag_q[b_idx];
        b_tgt = tgt_q[b_idx];
        b_st  = st_q[b_idx];
    end

endmodule

// File: rtl/branch_target_buffer.sv
module branch_target_buffer
    import btb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_pc,
    output logic              lk_hit,
    output logic              lk_taken,
    output logic [ADDR_W-1:0] lk_target,
    input  logic              up_valid,
    input  logic [ADDR_W-1:0] up_pc,
    input  logic              up_taken,
    input  logic [ADDR_W-1:0] up_target
);

    localparam int ENTRIES = 1 << IDX_W;
    localparam int TAG_W   = ADDR_W - IDX_W;

    logic [IDX_W-1:0]        lk_idx, up_idx;
    logic [TAG_W-1:0]        lk_tag, up_tag;
    logic                    a_vld, b_vld;
    logic [TAG_W-1:0]        a_tag, b_tag;
    logic [ADDR_W-1:0]       a_tgt, b_tgt;
    ctr_state_t              a_st, b_st;
    logic [ENTRIES-1:0]      vld_all;
    logic [ENTRIES-1:0][1:0] st_all;
    logic                    up_hit, we;
    ctr_state_t              wr_st;
    logic [ADDR_W-1:0]       wr_tgt;

    assign lk_idx = lk_pc[IDX_W-1:0];
    assign lk_tag = lk_pc[ADDR_W-1:IDX_W];
    assign up_idx = up_pc[IDX_W-1:0];
    assign up_tag = up_pc[ADDR_W-1:IDX_W];

    btb_storage #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_store (
        .clk(clk), .rst_n(rst_n),
        .we(we), .wr_idx(up_idx), .wr_tag(up_tag), .wr_tgt(wr_tgt), .wr_st(wr_st),
        .a_idx(lk_idx), .a_vld(a_vld), .a_tag(a_tag), .a_tgt(a_tgt), .a_st(a_st),
        .b_idx(up_idx), .b_vld(b_vld), .b_tag(b_tag), .b_tgt(b_tgt), .b_st(b_st),
        .vld_all(vld_all), .st_all(st_all)
    );

    // Update path: train on hit, allocate only on a taken miss.
    assign up_hit = b_vld && (b_tag == up_tag);
    assign we     = up_valid && (up_hit || up_taken);
    assign wr_tgt = up_taken ? up_target : b_tgt;

    btb_sat_counter i_ctr (
        .cur(b_st), .alloc(!up_hit), .taken(up_taken), .nxt(wr_st)
    );

    // Lookup outputs read the registered table only (pre-update view).
    always_comb begin
        lk_hit    = a_vld && (a_tag == lk_tag);
        lk_taken  = lk_hit && ctr_predicts_taken(a_st);
        lk_target = lk_hit ? a_tgt : '0;
    end

    // R4
    alloc_strong_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_taken && !up_hit) |=>
            (vld_all[$past(up_idx)] && st_all[$past(up_idx)] == 2'd3));

    // R3
    no_alloc_on_nt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !up_taken && !up_hit) |=> $stable(vld_all) && $stable(st_all));

    // R5
    sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_hit && up_taken && b_st == CNT_T_STRONG) |=>
            st_all[$past(up_idx)] == 2'd3);

    // R7
    strong_taken_decay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_hit && !up_taken && b_st == CNT_T_STRONG) |=>
            st_all[$past(up_idx)] == 2'd2);

    // R6
    sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_hit && !up_taken && b_st == CNT_NT_STRONG) |=>
            st_all[$past(up_idx)] == 2'd0);

endmodule

// File: tb/test_branch_target_buffer.sv
module test_branch_target_buffer;

    localparam int ADDR_W = 16;
    localparam int IDX_W  = 4;
    localparam int N      = 1 << IDX_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] lk_pc = '0;
    logic              lk_hit, lk_taken;
    logic [ADDR_W-1:0] lk_target;
    logic              up_valid = 1'b0;
    logic [ADDR_W-1:0] up_pc = '0;
    logic              up_taken = 1'b0;
    logic [ADDR_W-1:0] up_target = '0;

    int checks = 0;
    int fails  = 0;

    logic              m_vld [N];
    logic [11:0]       m_tag [N];
    logic [ADDR_W-1:0] m_tgt [N];
    int                m_st  [N];

    always #5 clk = ~clk;

    branch_target_buffer #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_branch_target_buffer (
        .clk(clk), .rst_n(rst_n),
        .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_taken(lk_taken), .lk_target(lk_target),
        .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken), .up_target(up_target)
    );

    function automatic logic [ADDR_W:0] expect_lookup(logic [ADDR_W-1:0] pc);
        int i = int'(pc[3:0]);
        logic h = m_vld[i] && (m_tag[i] == pc[15:4]);
        logic t = h && (m_st[i] >= 2);
        return {h, t, h ? m_tgt[i][ADDR_W-2:0] : '0} ^ {1'b0, 1'b0, {(ADDR_W-1){1'b0}}};
    endfunction

    task automatic model_update(logic [ADDR_W-1:0] pc, logic t, logic [ADDR_W-1:0] tgt);
        int i = int'(pc[3:0]);
        logic h = m_vld[i] && (m_tag[i] == pc[15:4]);
        if (h) begin
            if (t) begin
                m_st[i]  = (m_st[i] == 3) ? 3 : m_st[i] + 1;
                m_tgt[i] = tgt;
            end else begin
                m_st[i]  = (m_st[i] == 0) ? 0 : m_st[i] - 1;
            end
        end else if (t) begin
            m_vld[i] = 1'b1;
            m_tag[i] = pc[15:4];
            m_tgt[i] = tgt;
            m_st[i]  = 3;
        end
    endtask

    // One cycle: drive at negedge, check lookup against pre-update model, then clock.
    task automatic cyc(logic [ADDR_W-1:0] lpc, logic uv, logic [ADDR_W-1:0] upc,
                       logic ut, logic [ADDR_W-1:0] utgt, string req);
        int i;
        logic eh, et;
        logic [ADDR_W-1:0] etg;
        @(negedge clk);
        lk_pc = lpc; up_valid = uv; up_pc = upc; up_taken = ut; up_target = utgt;
        #1;
        i   = int'(lpc[3:0]);
        eh  = m_vld[i] && (m_tag[i] == lpc[15:4]);
        et  = eh && (m_st[i] >= 2);
        etg = eh ? m_tgt[i] : '0;
        checks++;
        if (lk_hit !== eh || lk_taken !== et || lk_target !== etg) begin
            fails++;
            $display("FAIL %s pc=%h actual hit=%b taken=%b tgt=%h expected hit=%b taken=%b tgt=%h",
                     req, lpc, lk_hit, lk_taken, lk_target, eh, et, etg);
        end
        if (uv) model_update(upc, ut, utgt);
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [ADDR_W-1:0] a, b;
        a = 16'h0125;
        b = 16'h0345;
        for (int k = 0; k < N; k++) begin
            m_vld[k] = 1'b0; m_tag[k] = '0; m_tgt[k] = '0; m_st[k] = 0;
        end
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, all misses
        cyc(a, 1'b0, '0, 1'b0, '0, "R1");
        cyc(16'hFFFF, 1'b0, '0, 1'b0, '0, "R1");
        // R2/R3: not-taken miss leaves nothing behind
        cyc(a, 1'b1, a, 1'b0, 16'h0AAA, "R2");
        cyc(a, 1'b0, '0, 1'b0, '0, "R3");
        // R9: same-cycle allocate, lookup sees the old (empty) slot
        cyc(a, 1'b1, a, 1'b1, 16'h1000, "R9");
        // R4: allocation in strongest state
        cyc(a, 1'b0, '0, 1'b0, '0, "R4");
        // R7: two not-taken outcomes from state 3 are needed to flip
        cyc(a, 1'b1, a, 1'b0, 16'h0BBB, "R7");
        cyc(a, 1'b1, a, 1'b0, 16'h0BBB, "R7");
        // R6: state 1, target kept
        cyc(a, 1'b1, a, 1'b0, 16'h0CCC, "R6");
        cyc(a, 1'b1, a, 1'b0, 16'h0CCC, "R6");
        cyc(a, 1'b0, '0, 1'b0, '0, "R6");
        // R5/R7: climb from 0, first taken refreshes target but still NT
        cyc(a, 1'b1, a, 1'b1, 16'h2000, "R5");
        cyc(a, 1'b1, a, 1'b1, 16'h2100, "R7");
        cyc(a, 1'b1, a, 1'b1, 16'h2200, "R7");
        cyc(a, 1'b1, a, 1'b1, 16'h2300, "R5");
        cyc(a, 1'b1, a, 1'b0, 16'h0000, "R5");
        cyc(a, 1'b0, '0, 1'b0, '0, "R5");
        // R8/R10: same index, different tag evicts
        cyc(b, 1'b1, b, 1'b1, 16'h3000, "R8");
        cyc(a, 1'b0, '0, 1'b0, '0, "R8");
        cyc(b, 1'b0, '0, 1'b0, '0, "R10");
        cyc(16'h0346, 1'b0, '0, 1'b0, '0, "R10");

        // Random phase over a small conflicting address pool
        for (int n = 0; n < 4000; n++) begin
            logic [ADDR_W-1:0] lp, upa, ut;
            logic uvv, utk;
            upa = {12'($urandom % 3), 4'($urandom % 4)};
            lp  = ($urandom % 4 == 0) ? upa : {12'($urandom % 3), 4'($urandom % 4)};
            uvv = ($urandom % 4) != 0;
            utk = ($urandom % 2) == 1;
            ut  = 16'($urandom);
            cyc(lp, uvv, upa, utk, ut, "R7");
        end

        @(negedge clk);
        up_valid = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule